// File: doc/BRIEF.md
# Inter-Processor Message Register Bank

This block holds a small bank of message registers through which one processor leaves a 32-bit word for another. Writing a message register stores the word and, when that register's enable bit is set, marks a message as pending. Each pending message drives its own interrupt line toward the receiving processor, gated by a per-register allow bit so that software can hold interrupts back without losing them.

The receiver acknowledges a message in either of two ways: by reading the message register, which returns the stored word and drops the pending flag in the same access, or by writing a 1 to that register's bit in the status register. All accesses use a plain single-cycle register bus: address, write strobe with write data, and read strobe with registered read data one cycle later. The bus carries no handshake; every strobe is accepted in the cycle it is presented.

Address map (word index on `addr`): 0 to 7 are the message registers, 8 is the enable register, 9 is the allow register (bit set means the interrupt may reach its output), 10 is the status register, 11 to 15 are unmapped.

Top module: `msg_reg_bank`

## Requirements
- R1: A write to address i (0 to 7) stores the full 32-bit `wr_data` in message register i; a read strobe at address i returns that word on `rd_data` in the cycle after the strobe, and the word is held until the next write to the same address.
- R2: A write to message register i sets its pending flag only when bit i of the enable register (address 8) is 1; with that bit 0 the word is still stored and the pending flag keeps its previous value.
- R3: `irq_o[i]` is high exactly when message i is pending and bit i of the allow register (address 9) is 1; the allow register resets to 0, so all interrupts start blocked, and a flag set while blocked appears on `irq_o` once its allow bit is written to 1.
- R4: A read of message register i clears its pending flag.
- R5: Writing the status register (address 10) clears pending flag i for every bit i of `wr_data[7:0]` that is 1; bits that are 0 leave their flags unchanged.
- R6: When a read of message register i and an enabled write to it fall in the same cycle, the read returns the old word, the new word is stored and the pending flag ends up set.
- R7: Reading the status register returns the eight pending flags in bits 7:0 with bits 31:8 zero, and has no side effect; the enable and allow registers read back their last written value in bits 7:0 with the upper bits zero.
- R8: Addresses 11 to 15 read as zero and writes to them change no state.
- R9: After reset all message words, pending flags, enable and allow bits and `rd_data` are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Word address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_o | output | 8 | One interrupt line per message register |

## Verification
The bench builds the block with its default parameters: eight message registers, 32-bit data and a 4-bit address. With only sixteen addresses and eight flags, it can sweep every address, every message index and several full enable and allow patterns, so each register's set, read-clear and write-1-clear paths, the blocked-then-allowed case and the same-cycle read-and-write collision are all exercised for every slot.

// File: rtl/msgb_pkg.sv
package msgb_pkg;

  typedef enum logic [2:0] {
    SEL_MSG   = 3'd0,
    SEL_EN    = 3'd1,
    SEL_ALLOW = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_NONE  = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/msgb_decode.sv
module msgb_decode
  import msgb_pkg::*;
#(
  parameter int NUM_MSG = 8,
  parameter int ADDR_W  = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [NUM_MSG-1:0] msg_wr,
  output logic [NUM_MSG-1:0] msg_rd,
  output logic               en_wr,
  output logic               allow_wr,
  output logic               stat_wr,
  output reg_sel_e           sel
);

  localparam logic [ADDR_W-1:0] EN_ADDR    = ADDR_W'(NUM_MSG);
  localparam logic [ADDR_W-1:0] ALLOW_ADDR = ADDR_W'(NUM_MSG + 1);
  localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(NUM_MSG + 2);

  always_comb begin
    if (addr < EN_ADDR)          sel = SEL_MSG;
    else if (addr == EN_ADDR)    sel = SEL_EN;
    else if (addr == ALLOW_ADDR) sel = SEL_ALLOW;
    else if (addr == STAT_ADDR)  sel = SEL_STAT;
    else                         sel = SEL_NONE;
  end

  for (genvar gi = 0; gi < NUM_MSG; gi++) begin : g_hit
    assign msg_wr[gi] = wr_en && (addr == ADDR_W'(gi));
    assign msg_rd[gi] = rd_en && (addr == ADDR_W'(gi));
  end

  assign en_wr    = wr_en && (sel == SEL_EN);
  assign allow_wr = wr_en && (sel == SEL_ALLOW);
  assign stat_wr  = wr_en && (sel == SEL_STAT);

endmodule

// File: rtl/msgb_slot.sv
module msgb_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_hit,
  input  logic              enable,
  input  logic              stat_clr,
  output logic [DATA_W-1:0] data_q,
  output logic              pend_q
);

  logic set_req;
  logic clr_req;

  assign set_req = wr_hit && enable;
  assign clr_req = rd_hit || stat_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_hit) begin
      data_q <= wr_data;
    end
  end

  // set has priority over any clear landing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (set_req) begin
      pend_q <= 1'b1;
    end else if (clr_req) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/msgb_readmux.sv
module msgb_readmux
  import msgb_pkg::*;
#(
  parameter int NUM_MSG = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  reg_sel_e                        sel,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_MSG-1:0][DATA_W-1:0]  msg_data,
  input  logic [NUM_MSG-1:0]              enable_q,
  input  logic [NUM_MSG-1:0]              allow_q,
  input  logic [NUM_MSG-1:0]              pend,
  output logic [DATA_W-1:0]               rd_data
);

  localparam int IDX_W = $clog2(NUM_MSG);
  localparam int PAD_W = DATA_W - NUM_MSG;

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_next;

  assign idx = addr[IDX_W-1:0];

  always_comb begin
    unique case (sel)
      SEL_MSG:   rd_next = msg_data[idx];
      SEL_EN:    rd_next = {{PAD_W{1'b0}}, enable_q};
      SEL_ALLOW: rd_next = {{PAD_W{1'b0}}, allow_q};
      SEL_STAT:  rd_next = {{PAD_W{1'b0}}, pend};
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/msg_reg_bank.sv
module msg_reg_bank
  import msgb_pkg::*;
#(
  parameter int NUM_MSG = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_MSG-1:0] irq_o
);

  logic [NUM_MSG-1:0]             msg_wr;
  logic [NUM_MSG-1:0]             msg_rd;
  logic                           en_wr;
  logic                           allow_wr;
  logic                           stat_wr;
  reg_sel_e                       sel;
  logic [NUM_MSG-1:0]             enable_q;
  logic [NUM_MSG-1:0]             allow_q;
  logic [NUM_MSG-1:0]             pend;
  logic [NUM_MSG-1:0]             stat_clr;
  logic [NUM_MSG-1:0][DATA_W-1:0] msg_data;

  msgb_decode #(
    .NUM_MSG (NUM_MSG),
    .ADDR_W  (ADDR_W)
  ) u_decode (
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .msg_wr   (msg_wr),
    .msg_rd   (msg_rd),
    .en_wr    (en_wr),
    .allow_wr (allow_wr),
    .stat_wr  (stat_wr),
    .sel      (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      allow_q  <= '0;
    end else begin
      if (en_wr)    enable_q <= wr_data[NUM_MSG-1:0];
      if (allow_wr) allow_q  <= wr_data[NUM_MSG-1:0];
    end
  end

  assign stat_clr = stat_wr ? wr_data[NUM_MSG-1:0] : '0;

  for (genvar gi = 0; gi < NUM_MSG; gi++) begin : g_slot
    msgb_slot #(
      .DATA_W (DATA_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (msg_wr[gi]),
      .wr_data  (wr_data),
      .rd_hit   (msg_rd[gi]),
      .enable   (enable_q[gi]),
      .stat_clr (stat_clr[gi]),
      .data_q   (msg_data[gi]),
      .pend_q   (pend[gi])
    );
  end

  assign irq_o = pend & allow_q;

  msgb_readmux #(
    .NUM_MSG (NUM_MSG),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_readmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .sel      (sel),
    .addr     (addr),
    .msg_data (msg_data),
    .enable_q (enable_q),
    .allow_q  (allow_q),
    .pend     (pend),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/msgb_checker.sv
module msgb_checker #(
  parameter int NUM_MSG = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               addr,
  input logic                            wr_en,
  input logic [DATA_W-1:0]               wr_data,
  input logic                            rd_en,
  input logic [NUM_MSG-1:0]              enable_q,
  input logic [NUM_MSG-1:0]              pend,
  input logic [NUM_MSG-1:0][DATA_W-1:0]  msg_data
);

  logic [NUM_MSG-1:0] wr_hit;
  logic [NUM_MSG-1:0] rd_hit;
  logic [NUM_MSG-1:0] w1c;
  logic [NUM_MSG-1:0] set_ok;

  for (genvar gi = 0; gi < NUM_MSG; gi++) begin : g_hit
    assign wr_hit[gi] = wr_en && (addr == ADDR_W'(gi));
    assign rd_hit[gi] = rd_en && (addr == ADDR_W'(gi));
  end
  assign w1c    = (wr_en && addr == ADDR_W'(NUM_MSG + 2)) ? wr_data[NUM_MSG-1:0] : '0;
  assign set_ok = wr_hit & enable_q;

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(set_ok)) == '0); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(rd_hit & ~set_ok)) == '0); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(w1c & ~set_ok)) == '0); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_ok) & ~pend) == '0); // R6

  for (genvar gi = 0; gi < NUM_MSG; gi++) begin : g_data
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[gi] |=> $stable(msg_data[gi])); // R1
    AST_DATA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[gi] |=> (msg_data[gi] == $past(wr_data))); // R1
  end

endmodule

bind msg_reg_bank msgb_checker #(
  .NUM_MSG (NUM_MSG),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_msgb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .enable_q (enable_q),
  .pend     (pend),
  .msg_data (msg_data)
);

// File: tb/test_msg_reg_bank.sv
module test_msg_reg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int DW  = 32;
  localparam int AW  = 4;
  localparam logic [AW-1:0] A_EN    = 4'd8;
  localparam logic [AW-1:0] A_ALLOW = 4'd9;
  localparam logic [AW-1:0] A_STAT  = 4'd10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [N-1:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW-1:0] m_data [N];
  logic [N-1:0]  m_pend = '0;
  logic [N-1:0]  m_en = '0;
  logic [N-1:0]  m_allow = '0;

  msg_reg_bank #(.NUM_MSG(N), .DATA_W(DW), .ADDR_W(AW)) i_msg_reg_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    if (a < 8)            return m_data[a[2:0]];
    else if (a == A_EN)    return {24'b0, m_en};
    else if (a == A_ALLOW) return {24'b0, m_allow};
    else if (a == A_STAT)  return {24'b0, m_pend};
    else                   return '0;
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (a < 8) begin
      m_data[a[2:0]] = d;
      if (m_en[a[2:0]]) m_pend[a[2:0]] = 1'b1;
    end else if (a == A_EN)    m_en = d[7:0];
    else if (a == A_ALLOW)     m_allow = d[7:0];
    else if (a == A_STAT)      m_pend = m_pend & ~d[7:0];
  endfunction

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] exp;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp = model_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_data, exp);
    if (a < 8) m_pend[a[2:0]] = 1'b0;
  endtask

  task automatic check_irq(input string tag);
    check(tag, {24'b0, irq_o}, {24'b0, m_pend & m_allow});
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int k);
    return (32'h9E37_79B9 * (i + 1)) ^ (32'h0101_0101 * k) ^ 32'(i << 28);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] en_pats [3];
    en_pats[0] = 8'h00; en_pats[1] = 8'hA5; en_pats[2] = 8'hFF;
    for (int i = 0; i < N; i++) m_data[i] = '0;

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rd_data reset", rd_data, '0);
    check("R9 irq reset", {24'b0, irq_o}, '0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) bus_rd(AW'(a), "R9 register reset value");

    // R1 R2 R3 R4 sweep over enable patterns
    for (int k = 0; k < 3; k++) begin
      bus_wr(A_EN, {24'hFFFFFF, en_pats[k]});
      bus_rd(A_EN, "R7 enable readback");
      for (int i = 0; i < N; i++) begin
        bus_wr(AW'(i), pat(i, k));
        check_irq("R3 blocked while allow is zero");
      end
      bus_rd(A_STAT, "R2 pending follows enable");
      bus_wr(A_ALLOW, 32'h0000_00FF);
      check_irq("R3 pending shows once allowed");
      for (int i = 0; i < N; i++) begin
        bus_rd(AW'(i), "R1 message readback");
        check_irq("R4 read clears pending");
      end
      bus_rd(A_STAT, "R4 status empty after reads");
      bus_wr(A_ALLOW, 32'h0);
      bus_rd(A_ALLOW, "R7 allow readback");
    end

    // R1 held: data unchanged across other traffic
    bus_wr(A_EN, 32'h0);
    for (int i = 0; i < N; i++) bus_wr(AW'(i), pat(i, 7));
    bus_wr(A_STAT, 32'hFF);
    for (int i = 0; i < N; i++) bus_rd(AW'(i), "R1 data held");

    // R5 write-one-to-clear, per bit
    bus_wr(A_EN, 32'hFF);
    bus_wr(A_ALLOW, 32'h5A);
    for (int b = 0; b < N; b++) begin
      for (int i = 0; i < N; i++) bus_wr(AW'(i), pat(i, b));
      bus_wr(A_STAT, 32'h0);
      bus_rd(A_STAT, "R5 zero write keeps flags");
      bus_wr(A_STAT, 32'(1 << b) | 32'hFFFF_FF00);
      bus_rd(A_STAT, "R5 one bit cleared");
      check_irq("R5 irq after clear");
      bus_wr(A_STAT, 32'hFF);
    end

    // R6 read and enabled write to the same slot in one cycle
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] old_w;
      bus_wr(AW'(i), pat(i, 11));
      old_w = m_data[i];
      @(negedge clk);
      addr = AW'(i); rd_en = 1'b1; wr_en = 1'b1; wr_data = pat(i, 12);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      check("R6 read returns old word", rd_data, old_w);
      m_data[i] = pat(i, 12);
      m_pend[i] = 1'b1;
      bus_rd(A_STAT, "R6 pending kept set");
      bus_rd(AW'(i), "R6 new word stored");
    end

    // R8 unmapped addresses
    bus_wr(A_EN, 32'h3C);
    bus_wr(A_ALLOW, 32'hC3);
    bus_wr(AW'(2), 32'h1234_5678);
    for (int a = 11; a < 16; a++) begin
      bus_wr(AW'(a), 32'hFFFF_FFFF);
      bus_rd(AW'(a), "R8 unmapped reads zero");
    end
    bus_rd(A_EN, "R8 enable untouched");
    bus_rd(A_ALLOW, "R8 allow untouched");
    bus_rd(A_STAT, "R8 status untouched");
    check_irq("R8 irq untouched");
    for (int i = 0; i < N; i++) bus_rd(AW'(i), "R8 messages untouched");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule